// File: doc/BRIEF.md
# Circular Reorder Buffer with Selective Flush

This block keeps dispatched instructions in program order while their results arrive in any order. Dispatch claims the slot under the write pointer and receives that slot number as the instruction's tag. The result bus later writes the result value and an exception flag into the slot named by a tag. The oldest slot, at the read pointer, retires to the register file once its result is present. Slots are numbered modulo the buffer size, so both pointers wrap from the last slot back to slot 0.

When a branch turns out to be mispredicted, the pipeline sends the branch's tag. Only the younger part of the buffer is discarded. The distance of each slot from the read pointer is computed modulo the buffer size, and every slot at least as far from the head as the branch is dropped. This removes the branch and every instruction dispatched after it. The write pointer then returns to the branch's slot. Entries older than the branch stay and retire normally. An entry that reaches the head carrying an exception stops retirement and raises an exception output. It does not write the register file.

Top module: `rob_ring`

## Requirements
- R1: After reset the buffer is empty: `fillCount` is 0, `dispReady` is 1, `dispTag` is 0, and both `commitValid` and `excOut` are 0.
- R2: An accepted dispatch takes the slot number shown on `dispTag` (the write pointer). Successive dispatches get consecutive numbers.
- R3: With 31 entries held (one slot always free), `dispReady` is 0. A dispatch request in that state changes neither `fillCount` nor `dispTag`.
- R4: A completion marks the slot named by `cmplTag` as done and stores `cmplData` and `cmplExc` there. A completion aimed at a slot that holds no entry is ignored, so a later dispatch into that slot starts as not done.
- R5: While the head entry is done without an exception, `commitValid` is 1 in that same cycle. `commitDest` and `commitData` then carry the entry's destination register and result, and `commitWrEn` equals the entry's register-write flag. The head advances at the next clock edge.
- R6: An entry that has completed but is not at the head does not retire. `commitValid` stays 0 while the head entry is not done.
- R7: `fillCount` equals (write pointer minus read pointer) modulo 32.
- R8: A flush with `flushTag` inside the occupied range removes the branch slot and all younger entries. The write pointer becomes `flushTag`, and `fillCount` becomes the branch's distance from the head. A flush whose tag is not an occupied slot is ignored.
- R9: A flush takes priority over a dispatch in the same cycle, and that dispatch is dropped. A commit in the same cycle still advances the head, unless the flushed branch is itself the head.
- R10: A head entry that is done with its exception flag set raises `excOut`, with `excTag` set to its slot. `commitValid` stays 0 and the head does not move until a flush removes the entry.
- R11: Pointer, occupancy and flush-distance arithmetic wrap from slot 31 to slot 0, both for dispatch tags and for deciding which slots a flush removes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispDest | input | 5 | Destination register of the dispatched instruction |
| dispWrEn | input | 1 | Dispatched instruction writes a register |
| dispReady | output | 1 | Buffer can accept a dispatch |
| dispTag | output | 5 | Slot the next dispatch will take |
| cmplValid | input | 1 | Result bus carries a completion |
| cmplTag | input | 5 | Slot of the completing instruction |
| cmplData | input | 32 | Result value |
| cmplExc | input | 1 | Completing instruction raised an exception |
| commitValid | output | 1 | Head entry retires this cycle |
| commitWrEn | output | 1 | Register file write enable for the retiring entry |
| commitDest | output | 5 | Register written by the retiring entry |
| commitData | output | 32 | Value written by the retiring entry |
| excOut | output | 1 | Head entry holds an exception; retirement halted |
| excTag | output | 5 | Slot of the excepting head entry |
| flushValid | input | 1 | Branch misprediction flush |
| flushTag | input | 5 | Slot of the mispredicted branch |
| fillCount | output | 5 | Number of occupied slots |

## Verification
The hardest cases to reach from the ports are the flushes that depend on where the head sits. One is a flush issued while the buffer has wrapped past slot 31. There, a plain comparison of slot numbers would pick the wrong victims. The other is a flush that lands in the same cycle as a retirement. The stimulus fills the buffer to its 31-entry limit starting from a non-zero head, and cuts it back with a flush while full. It then lines up a completed head with a flush of a younger branch. Finally it refills from slot 11 past the wrap and flushes at slot 30, then sends a tag below the new write pointer to show that it is treated as unoccupied.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Strobes issued by the control block to the slot storage each cycle.
  typedef struct packed {
    logic allocEn;   // write a fresh entry at the tail
    logic retireEn;  // drop the head entry
    logic killEn;    // selective flush of the younger region
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             flushValid,
  input  logic [TAG_W-1:0] flushTag,
  input  logic             headValid,
  input  logic             headDone,
  input  logic             headExc,
  output logic [TAG_W-1:0] wrPtr,
  output logic [TAG_W-1:0] rdPtr,
  output logic [TAG_W-1:0] fillCount,
  output logic [TAG_W-1:0] killDepth,
  output robStrobe_t       strb,
  output logic             dispReady,
  output logic             commitFire,
  output logic             excFlag
);

  localparam logic [TAG_W-1:0] FULL_FILL = TAG_W'(DEPTH - 1);

  logic             isEmpty;
  logic             isFull;
  logic [TAG_W-1:0] brDepth;
  logic             flushOk;
  logic             headHit;
  logic             headReady;

  // Modular distances measured from the head.
  assign fillCount = wrPtr - rdPtr;
  assign brDepth   = flushTag - rdPtr;
  assign isEmpty   = (fillCount == '0);
  assign isFull    = (fillCount == FULL_FILL);

  // A flush only acts when its tag lies inside the occupied window.
  assign flushOk   = flushValid && (brDepth < fillCount);
  assign headHit   = flushOk && (brDepth == '0);

  assign headReady  = !isEmpty && headValid && headDone;
  assign commitFire = headReady && !headExc && !headHit;
  assign excFlag    = headReady && headExc;
  assign dispReady  = !isFull;
  assign killDepth  = brDepth;

  always_comb begin
    strb          = '0;
    strb.allocEn  = dispValid && !isFull && !flushOk;
    strb.retireEn = commitFire;
    strb.killEn   = flushOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (flushOk) begin
        wrPtr <= flushTag;
      end else if (strb.allocEn) begin
        wrPtr <= wrPtr + 1'b1;
      end
      if (commitFire) begin
        rdPtr <= rdPtr + 1'b1;
      end
    end
  end

  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> !strb.allocEn); // R3
  AST_EMPTY_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> !commitFire); // R6
  AST_HEAD_OCCUPIED: assert property (@(posedge clk) disable iff (!rstN)
    !isEmpty |-> headValid); // R2
  AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    commitFire |=> rdPtr == TAG_W'($past(rdPtr) + 1'b1)); // R5
  AST_EXC_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    excFlag |=> rdPtr == $past(rdPtr)); // R10
  AST_FLUSH_REWIND: assert property (@(posedge clk) disable iff (!rstN)
    flushOk |=> wrPtr == $past(flushTag)); // R8

endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobe_t        strb,
  input  logic [TAG_W-1:0]  allocIdx,
  input  logic [REG_W-1:0]  allocDest,
  input  logic              allocWrEn,
  input  logic [TAG_W-1:0]  headIdx,
  input  logic [TAG_W-1:0]  killDepth,
  input  logic              cmplValid,
  input  logic [TAG_W-1:0]  cmplTag,
  input  logic [DATA_W-1:0] cmplData,
  input  logic              cmplExc,
  output logic              headValid,
  output logic              headDone,
  output logic              headExc,
  output logic              headWrEn,
  output logic [REG_W-1:0]  headDest,
  output logic [DATA_W-1:0] headData
);

  logic [DEPTH-1:0]  validVec;
  logic [DEPTH-1:0]  doneVec;
  logic [DEPTH-1:0]  excVec;
  logic [DEPTH-1:0]  wrEnVec;
  logic [REG_W-1:0]  destArr [DEPTH];
  logic [DATA_W-1:0] dataArr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              vQ;
    logic              dQ;
    logic              eQ;
    logic              wQ;
    logic [REG_W-1:0]  rQ;
    logic [DATA_W-1:0] xQ;
    logic [TAG_W-1:0]  slotDepth;
    logic              killMe;
    logic              allocMe;
    logic              retireMe;
    logic              cmplMe;

    assign slotDepth = TAG_W'(i) - headIdx;
    assign killMe    = strb.killEn && (slotDepth >= killDepth);
    assign allocMe   = strb.allocEn && (allocIdx == TAG_W'(i));
    assign retireMe  = strb.retireEn && (headIdx == TAG_W'(i));
    assign cmplMe    = cmplValid && (cmplTag == TAG_W'(i)) && vQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vQ <= 1'b0;
        dQ <= 1'b0;
        eQ <= 1'b0;
      end else if (killMe) begin
        vQ <= 1'b0;
      end else if (allocMe) begin
        vQ <= 1'b1;
        dQ <= 1'b0;
        eQ <= 1'b0;
      end else begin
        if (retireMe) vQ <= 1'b0;
        if (cmplMe) begin
          dQ <= 1'b1;
          eQ <= cmplExc;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (allocMe) begin
        rQ <= allocDest;
        wQ <= allocWrEn;
      end
      if (cmplMe) xQ <= cmplData;
    end

    assign validVec[i] = vQ;
    assign doneVec[i]  = dQ;
    assign excVec[i]   = eQ;
    assign wrEnVec[i]  = wQ;
    assign destArr[i]  = rQ;
    assign dataArr[i]  = xQ;
  end

  assign headValid = validVec[headIdx];
  assign headDone  = doneVec[headIdx];
  assign headExc   = excVec[headIdx];
  assign headWrEn  = wrEnVec[headIdx];
  assign headDest  = destArr[headIdx];
  assign headData  = dataArr[headIdx];

  logic cmplLands;
  assign cmplLands = cmplValid && validVec[cmplTag] && !strb.killEn;

  AST_CMPL_MARKS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    cmplLands |=> doneVec[$past(cmplTag)]); // R4
  AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    strb.allocEn |=> validVec[$past(allocIdx)] && !doneVec[$past(allocIdx)]); // R2

endmodule

// File: rtl/rob_ring.sv
module rob_ring
  import rob_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic [REG_W-1:0]  dispDest,
  input  logic              dispWrEn,
  output logic              dispReady,
  output logic [TAG_W-1:0]  dispTag,
  input  logic              cmplValid,
  input  logic [TAG_W-1:0]  cmplTag,
  input  logic [DATA_W-1:0] cmplData,
  input  logic              cmplExc,
  output logic              commitValid,
  output logic              commitWrEn,
  output logic [REG_W-1:0]  commitDest,
  output logic [DATA_W-1:0] commitData,
  output logic              excOut,
  output logic [TAG_W-1:0]  excTag,
  input  logic              flushValid,
  input  logic [TAG_W-1:0]  flushTag,
  output logic [TAG_W-1:0]  fillCount
);

  robStrobe_t       strb;
  logic [TAG_W-1:0] wrPtr;
  logic [TAG_W-1:0] rdPtr;
  logic [TAG_W-1:0] killDepth;
  logic             headValid;
  logic             headDone;
  logic             headExc;
  logic             headWrEn;
  logic             commitFire;
  logic             excFlag;

  rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dispValid  (dispValid),
    .flushValid (flushValid),
    .flushTag   (flushTag),
    .headValid  (headValid),
    .headDone   (headDone),
    .headExc    (headExc),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .fillCount  (fillCount),
    .killDepth  (killDepth),
    .strb       (strb),
    .dispReady  (dispReady),
    .commitFire (commitFire),
    .excFlag    (excFlag)
  );

  rob_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .allocIdx  (wrPtr),
    .allocDest (dispDest),
    .allocWrEn (dispWrEn),
    .headIdx   (rdPtr),
    .killDepth (killDepth),
    .cmplValid (cmplValid),
    .cmplTag   (cmplTag),
    .cmplData  (cmplData),
    .cmplExc   (cmplExc),
    .headValid (headValid),
    .headDone  (headDone),
    .headExc   (headExc),
    .headWrEn  (headWrEn),
    .headDest  (commitDest),
    .headData  (commitData)
  );

  assign dispTag     = wrPtr;
  assign commitValid = commitFire;
  assign commitWrEn  = commitFire && headWrEn;
  assign excOut      = excFlag;
  assign excTag      = rdPtr;

endmodule

// File: tb/rob_ring_tb.sv
`timescale 1ns/1ps
module rob_ring_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dispValid = 1'b0;
  logic [4:0]  dispDest = '0;
  logic        dispWrEn = 1'b0;
  logic        dispReady;
  logic [4:0]  dispTag;
  logic        cmplValid = 1'b0;
  logic [4:0]  cmplTag = '0;
  logic [31:0] cmplData = '0;
  logic        cmplExc = 1'b0;
  logic        commitValid;
  logic        commitWrEn;
  logic [4:0]  commitDest;
  logic [31:0] commitData;
  logic        excOut;
  logic [4:0]  excTag;
  logic        flushValid = 1'b0;
  logic [4:0]  flushTag = '0;
  logic [4:0]  fillCount;

  int nChecks = 0;
  int nFails  = 0;
  bit doneRun = 1'b0;

  always #2 clk = ~clk;

  rob_ring u_dut (
    .clk(clk), .rstN(rstN),
    .dispValid(dispValid), .dispDest(dispDest), .dispWrEn(dispWrEn),
    .dispReady(dispReady), .dispTag(dispTag),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplData(cmplData), .cmplExc(cmplExc),
    .commitValid(commitValid), .commitWrEn(commitWrEn),
    .commitDest(commitDest), .commitData(commitData),
    .excOut(excOut), .excTag(excTag),
    .flushValid(flushValid), .flushTag(flushTag), .fillCount(fillCount)
  );

  // {wrEn, dest, data}
  localparam logic [37:0] VEC [8] = '{
    {1'b1, 5'd2,  32'h0000_1111},
    {1'b0, 5'd5,  32'h2222_0000},
    {1'b1, 5'd31, 32'hFFFF_FFFF},
    {1'b1, 5'd0,  32'h0000_0000},
    {1'b1, 5'd17, 32'hA5A5_5A5A},
    {1'b0, 5'd9,  32'h1234_5678},
    {1'b1, 5'd3,  32'hDEAD_BEEF},
    {1'b1, 5'd30, 32'h0BAD_F00D}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    dispValid  = 1'b0;
    cmplValid  = 1'b0;
    cmplExc    = 1'b0;
    flushValid = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    check(fillCount == 0, "R1", "fillCount", fillCount, 0);
    check(dispReady == 1, "R1", "dispReady", dispReady, 1);
    check(dispTag == 0, "R1", "dispTag", dispTag, 0);
    check(commitValid == 0, "R1", "commitValid", commitValid, 0);
    check(excOut == 0, "R1", "excOut", excOut, 0);

    // Table walk: dispatch in order, complete in reverse, retire in order
    for (int i = 0; i < 8; i++) begin
      dispValid = 1'b1;
      dispDest  = VEC[i][36:32];
      dispWrEn  = VEC[i][37];
      #1;
      check(dispTag == 5'(i), "R2", "dispTag", dispTag, i);
      tick();
    end
    quiet();
    check(fillCount == 8, "R7", "fillCount", fillCount, 8);
    for (int i = 7; i >= 1; i--) begin
      cmplValid = 1'b1;
      cmplTag   = 5'(i);
      cmplData  = VEC[i][31:0];
      tick();
      check(commitValid == 0, "R6", "commitValid while head pending", commitValid, 0);
    end
    cmplTag  = 5'd0;
    cmplData = VEC[0][31:0];
    tick();
    quiet();
    for (int k = 0; k < 8; k++) begin
      check(commitValid == 1, "R5", "commitValid", commitValid, 1);
      check(commitDest == VEC[k][36:32], "R5", "commitDest", commitDest, VEC[k][36:32]);
      check(commitData == VEC[k][31:0], "R5", "commitData", commitData, VEC[k][31:0]);
      check(commitWrEn == VEC[k][37], "R5", "commitWrEn", commitWrEn, VEC[k][37]);
      tick();
    end
    check(fillCount == 0, "R7", "fillCount drained", fillCount, 0);
    check(commitValid == 0, "R6", "commitValid empty", commitValid, 0);

    // Fill to the limit from head 8 (tags wrap past 31)
    for (int i = 0; i < 31; i++) begin
      dispValid = 1'b1;
      dispDest  = 5'(i);
      dispWrEn  = 1'b1;
      tick();
    end
    check(fillCount == 31, "R3", "fillCount full", fillCount, 31);
    check(dispReady == 0, "R3", "dispReady full", dispReady, 0);
    check(dispTag == 7, "R11", "dispTag wrapped", dispTag, 7);
    tick();
    check(fillCount == 31, "R3", "dispatch ignored when full", fillCount, 31);
    check(dispTag == 7, "R3", "dispTag unchanged when full", dispTag, 7);

    // Flush at slot 12 (distance 4) while a dispatch is requested
    flushValid = 1'b1;
    flushTag   = 5'd12;
    tick();
    quiet();
    check(fillCount == 4, "R8", "fillCount after flush", fillCount, 4);
    check(dispTag == 12, "R9", "dispTag after flush+dispatch", dispTag, 12);

    // Flush aimed outside the occupied window
    flushValid = 1'b1;
    flushTag   = 5'd20;
    tick();
    quiet();
    check(fillCount == 4, "R8", "out-of-range flush ignored", fillCount, 4);

    // Commit and flush in the same cycle
    cmplValid = 1'b1;
    cmplTag   = 5'd8;
    cmplData  = 32'h88;
    tick();
    quiet();
    check(commitValid == 1, "R9", "head ready before flush", commitValid, 1);
    flushValid = 1'b1;
    flushTag   = 5'd10;
    tick();
    quiet();
    check(fillCount == 1, "R9", "commit advanced during flush", fillCount, 1);
    cmplValid = 1'b1;
    cmplTag   = 5'd9;
    cmplData  = 32'h99;
    tick();
    quiet();
    check(commitValid == 1 && commitData == 32'h99, "R5", "slot 9 commit data", commitData, 32'h99);
    tick();
    check(fillCount == 0, "R7", "fillCount empty at 10", fillCount, 0);

    // Completion to an empty slot is ignored
    cmplValid = 1'b1;
    cmplTag   = 5'd10;
    cmplData  = 32'hDEAD;
    tick();
    quiet();
    dispValid = 1'b1;
    dispDest  = 5'd4;
    dispWrEn  = 1'b1;
    #1;
    check(dispTag == 10, "R2", "dispTag 10", dispTag, 10);
    tick();
    quiet();
    check(commitValid == 0, "R4", "stray completion ignored", commitValid, 0);
    cmplValid = 1'b1;
    cmplTag   = 5'd10;
    cmplData  = 32'h77;
    tick();
    quiet();
    check(commitValid == 1 && commitData == 32'h77, "R4", "completion data", commitData, 32'h77);
    tick();

    // Exception at the head halts retirement
    dispValid = 1'b1;
    dispDest  = 5'd6;
    tick();
    quiet();
    cmplValid = 1'b1;
    cmplTag   = 5'd11;
    cmplData  = 32'h5;
    cmplExc   = 1'b1;
    tick();
    quiet();
    check(excOut == 1, "R10", "excOut", excOut, 1);
    check(excTag == 11, "R10", "excTag", excTag, 11);
    check(commitValid == 0, "R10", "no commit on exception", commitValid, 0);
    tick();
    check(fillCount == 1 && excOut == 1, "R10", "head held", fillCount, 1);
    flushValid = 1'b1;
    flushTag   = 5'd11;
    tick();
    quiet();
    check(fillCount == 0, "R8", "flush of head entry", fillCount, 0);
    check(excOut == 0, "R10", "excOut cleared by flush", excOut, 0);

    // Wrapped window: head 11, 25 entries, tail at 4
    for (int i = 0; i < 25; i++) begin
      dispValid = 1'b1;
      dispDest  = 5'(i);
      tick();
    end
    quiet();
    check(fillCount == 25 && dispTag == 4, "R11", "wrapped fill", fillCount, 25);
    flushValid = 1'b1;
    flushTag   = 5'd30;
    tick();
    quiet();
    check(fillCount == 19, "R11", "wrapped flush fill", fillCount, 19);
    check(dispTag == 30, "R11", "wrapped flush tail", dispTag, 30);
    flushValid = 1'b1;
    flushTag   = 5'd1;
    tick();
    quiet();
    check(fillCount == 19, "R11", "flush below tail after wrap ignored", fillCount, 19);

    doneRun = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule